// File: doc/BRIEF.md
# Instruction-Boundary Event Prioritizer

This block sits beside the sequencer of a small processor core and is consulted once per instruction boundary. When the sequencer raises its boundary strobe, the block looks at everything that may be waiting: pending debug-trap bits, a one-boundary inhibit mask, the interrupt request with its enable flag, and a bus-hold request. It answers with exactly one registered action pulse in the next cycle. The answer is one of: raise a debug exception, acknowledge an interrupt, grant the bus hold, or carry on and fetch.

The block also owns a halted state. After a halt request it ignores boundaries and waits, cycle by cycle, for an enabled interrupt request. When that arrives it emits a wake pulse and discards every pending trap and inhibit. Trap bits from breakpoint comparators and from single-stepping collect in a pending vector. When a debug exception is raised, they are ORed into a sticky debug status value. A combinational pending flag tells the sequencer whether a boundary evaluation can find anything to do.

All pins are plain control and status levels or pulses. No data stream crosses the block's edge, so it has no valid/ready handshake and no back-pressure.

Top module: `bep_event_prio`

## Requirements
- R1: While rst_n is low and after it rises, all action pulses are low, the debug status value is zero, and the pending trap vector and inhibit mask are empty.
- R2: An evaluation happens in a cycle where boundary_i is high and the block is not halted. The evaluation produces exactly one of dbg_exc_o, int_ack_o, hold_ack_o or fetch_o, high for the single cycle after that edge. No action pulse appears without an evaluation, except wake_o.
- R3: A halt_i pulse puts the block in the halted state, where boundaries produce no action. In the halted state, the first cycle with irq_i and int_en_i both high gives a wake_o pulse one cycle later. The same edge leaves the halted state and clears all pending trap bits and the inhibit mask.
- R4: A pending task-switch trap (trap vector bit TASK_BIT, 15 by default) wins over every other event, even when debug traps are inhibited. Servicing it raises dbg_exc_o, ORs the whole pending vector into dbg_status_o and empties the vector.
- R5: Other pending trap bits raise dbg_exc_o only when the debug-inhibit bit (inhibit mask bit 1) is clear. When that bit is set they stay pending until the next boundary.
- R6: With no debug exception due, an interrupt is taken when irq_i and int_en_i are high and the interrupt-inhibit bit (inhibit mask bit 0) is clear. Taking it pulses int_ack_o together with ext_evt_o.
- R7: hold_req_i is granted with hold_ack_o only on a boundary where neither a debug exception nor an interrupt is taken.
- R8: A boundary with nothing to service pulses fetch_o.
- R9: Suppose step_i is high at an evaluation that does not raise a debug exception. Then the single-step bit (trap vector bit STEP_BIT, 14 by default) becomes pending, and it is reported by a debug exception at a later boundary.
- R10: pending_o is low only when irq_i, hold_req_i and step_i are all low and no trap bit is pending.
- R11: inh_set_i ORs bits into the inhibit mask, and every evaluation clears the mask after using it. A bit set in the same cycle as an evaluation therefore applies to the next boundary only.
- R12: trap_set_i ORs bits into the pending vector in any cycle. Bits arriving in an evaluation cycle survive that evaluation's clearing and are first seen at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe, requests an evaluation |
| halt_i | input | 1 | Enter the halted state |
| trap_set_i | input | TRAP_W | Trap bits to add to the pending vector |
| inh_set_i | input | 2 | Inhibit bits for the next boundary: bit 0 interrupts, bit 1 debug traps |
| irq_i | input | 1 | External interrupt request level |
| int_en_i | input | 1 | Interrupt-enable flag |
| hold_req_i | input | 1 | Bus-hold request |
| step_i | input | 1 | Single-step flag |
| wake_o | output | 1 | Leave-halt pulse |
| dbg_exc_o | output | 1 | Debug exception pulse |
| int_ack_o | output | 1 | Interrupt acknowledge pulse |
| hold_ack_o | output | 1 | Bus-hold grant pulse |
| fetch_o | output | 1 | Proceed-to-fetch pulse |
| ext_evt_o | output | 1 | Marks the current action as an external event |
| dbg_status_o | output | TRAP_W | Sticky debug status, trap bits ORed in on each debug exception |
| pending_o | output | 1 | Something may need servicing at a boundary |

## Verification
The bench uses the default parameters: a 32-bit trap vector with the task-switch trap on bit 15 and single-step on bit 14. This puts both dedicated bits next to ordinary comparator bits such as 2, 3, 5 and 7. The status checks can then tell a task-switch trap that overrides the debug inhibit from ordinary traps that the inhibit holds back. The status value is also checked to accumulate across several exceptions. With the same settings, the bench can set an inhibit or a trap bit in the evaluation cycle itself and see it take effect one boundary later. It can also show that waking from halt discards a trap which would otherwise win the next boundary.

// File: rtl/bep_pkg.sv
`timescale 1ns/1ps
package bep_pkg;
  // Action chosen for the current cycle
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_WAKE  = 3'd1,
    ACT_DBG   = 3'd2,
    ACT_INT   = 3'd3,
    ACT_HOLD  = 3'd4,
    ACT_FETCH = 3'd5
  } act_e;

  // Inhibit mask layout
  localparam int INH_W   = 2;
  localparam int INH_INT = 0;
  localparam int INH_DBG = 1;
endpackage

// File: rtl/bep_halt_ctl.sv
`timescale 1ns/1ps
module bep_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_i,
  input  logic irq_i,
  input  logic int_en_i,
  output logic halted_o,
  output logic wake_req_o
);
  logic halted_q;

  // Wake condition seen while halted
  assign wake_req_o = halted_q & irq_i & int_en_i;
  assign halted_o   = halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          halted_q <= 1'b0;
    else if (wake_req_o) halted_q <= 1'b0;
    else if (halt_i)     halted_q <= 1'b1;
  end
endmodule

// File: rtl/bep_trap_store.sv
`timescale 1ns/1ps
module bep_trap_store
  import bep_pkg::*;
#(
  parameter int TRAP_W   = 32,
  parameter int STEP_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic              consume_i,
  input  logic              wake_i,
  input  logic              step_sched_i,
  input  logic [TRAP_W-1:0] trap_set_i,
  input  logic [INH_W-1:0]  inh_set_i,
  output logic [TRAP_W-1:0] trap_o,
  output logic [INH_W-1:0]  inh_o
);
  logic [TRAP_W-1:0] trap_q, trap_d;
  logic [INH_W-1:0]  inh_q, inh_d;

  always_comb begin
    trap_d = trap_q;
    inh_d  = inh_q;
    if (wake_i) begin
      trap_d = '0;
      inh_d  = '0;
    end else begin
      if (consume_i)    trap_d = '0;
      if (step_sched_i) trap_d[STEP_BIT] = 1'b1;
      trap_d = trap_d | trap_set_i;
      if (eval_i)       inh_d = '0;
      inh_d = inh_d | inh_set_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q <= '0;
      inh_q  <= '0;
    end else begin
      trap_q <= trap_d;
      inh_q  <= inh_d;
    end
  end

  assign trap_o = trap_q;
  assign inh_o  = inh_q;
endmodule

// File: rtl/bep_arbiter.sv
`timescale 1ns/1ps
module bep_arbiter
  import bep_pkg::*;
#(
  parameter int TRAP_W   = 32,
  parameter int TASK_BIT = 15
) (
  input  logic              halted_i,
  input  logic              wake_req_i,
  input  logic              boundary_i,
  input  logic [TRAP_W-1:0] trap_i,
  input  logic [INH_W-1:0]  inh_i,
  input  logic              irq_i,
  input  logic              int_en_i,
  input  logic              hold_req_i,
  output act_e              act_o
);
  logic task_trap, any_trap, int_ok;

  assign task_trap = trap_i[TASK_BIT];
  assign any_trap  = |trap_i;
  assign int_ok    = irq_i & int_en_i & ~inh_i[INH_INT];

  // Fixed boundary priority: task trap, debug traps, interrupt, hold, fetch
  always_comb begin
    act_o = ACT_NONE;
    if (halted_i) begin
      if (wake_req_i) act_o = ACT_WAKE;
    end else if (boundary_i) begin
      if (task_trap)                          act_o = ACT_DBG;
      else if (any_trap && !inh_i[INH_DBG])   act_o = ACT_DBG;
      else if (int_ok)                        act_o = ACT_INT;
      else if (hold_req_i)                    act_o = ACT_HOLD;
      else                                    act_o = ACT_FETCH;
    end
  end
endmodule

// File: rtl/bep_action_reg.sv
`timescale 1ns/1ps
module bep_action_reg
  import bep_pkg::*;
#(
  parameter int TRAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act_i,
  input  logic [TRAP_W-1:0] trap_i,
  output logic              wake_o,
  output logic              dbg_exc_o,
  output logic              int_ack_o,
  output logic              hold_ack_o,
  output logic              fetch_o,
  output logic              ext_evt_o,
  output logic [TRAP_W-1:0] dbg_status_o
);
  logic              commit_dbg;
  logic [TRAP_W-1:0] status_q;

  assign commit_dbg = (act_i == ACT_DBG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_o     <= 1'b0;
      dbg_exc_o  <= 1'b0;
      int_ack_o  <= 1'b0;
      hold_ack_o <= 1'b0;
      fetch_o    <= 1'b0;
      ext_evt_o  <= 1'b0;
    end else begin
      wake_o     <= (act_i == ACT_WAKE);
      dbg_exc_o  <= commit_dbg;
      int_ack_o  <= (act_i == ACT_INT);
      hold_ack_o <= (act_i == ACT_HOLD);
      fetch_o    <= (act_i == ACT_FETCH);
      ext_evt_o  <= (act_i == ACT_INT);
    end
  end

  // Sticky status bits, one flop per trap bit
  for (genvar b = 0; b < TRAP_W; b++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rst_n)                       status_q[b] <= 1'b0;
      else if (commit_dbg && trap_i[b]) status_q[b] <= 1'b1;
    end
  end

  assign dbg_status_o = status_q;
endmodule

// File: rtl/bep_event_prio.sv
`timescale 1ns/1ps
module bep_event_prio
  import bep_pkg::*;
#(
  parameter int TRAP_W   = 32,
  parameter int TASK_BIT = 15,
  parameter int STEP_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              halt_i,
  input  logic [TRAP_W-1:0] trap_set_i,
  input  logic [1:0]        inh_set_i,
  input  logic              irq_i,
  input  logic              int_en_i,
  input  logic              hold_req_i,
  input  logic              step_i,
  output logic              wake_o,
  output logic              dbg_exc_o,
  output logic              int_ack_o,
  output logic              hold_ack_o,
  output logic              fetch_o,
  output logic              ext_evt_o,
  output logic [TRAP_W-1:0] dbg_status_o,
  output logic              pending_o
);
  logic              halted, wake_req, eval, step_sched;
  logic [TRAP_W-1:0] trap_vec;
  logic [INH_W-1:0]  inh_vec;
  act_e              act;

  bep_halt_ctl u_halt (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_i     (halt_i),
    .irq_i      (irq_i),
    .int_en_i   (int_en_i),
    .halted_o   (halted),
    .wake_req_o (wake_req)
  );

  assign eval       = boundary_i & ~halted;
  assign step_sched = eval & step_i & (act != ACT_DBG);

  bep_trap_store #(.TRAP_W(TRAP_W), .STEP_BIT(STEP_BIT)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_i       (eval),
    .consume_i    (act == ACT_DBG),
    .wake_i       (wake_req),
    .step_sched_i (step_sched),
    .trap_set_i   (trap_set_i),
    .inh_set_i    (inh_set_i),
    .trap_o       (trap_vec),
    .inh_o        (inh_vec)
  );

  bep_arbiter #(.TRAP_W(TRAP_W), .TASK_BIT(TASK_BIT)) u_arb (
    .halted_i   (halted),
    .wake_req_i (wake_req),
    .boundary_i (boundary_i),
    .trap_i     (trap_vec),
    .inh_i      (inh_vec),
    .irq_i      (irq_i),
    .int_en_i   (int_en_i),
    .hold_req_i (hold_req_i),
    .act_o      (act)
  );

  bep_action_reg #(.TRAP_W(TRAP_W)) u_act (
    .clk          (clk),
    .rst_n        (rst_n),
    .act_i        (act),
    .trap_i       (trap_vec),
    .wake_o       (wake_o),
    .dbg_exc_o    (dbg_exc_o),
    .int_ack_o    (int_ack_o),
    .hold_ack_o   (hold_ack_o),
    .fetch_o      (fetch_o),
    .ext_evt_o    (ext_evt_o),
    .dbg_status_o (dbg_status_o)
  );

  assign pending_o = irq_i | hold_req_i | step_i | (|trap_vec);
endmodule

// File: rtl/bep_checker.sv
`timescale 1ns/1ps
module bep_checker #(
  parameter int TRAP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              irq_i,
  input logic              int_en_i,
  input logic              hold_req_i,
  input logic              wake_o,
  input logic              dbg_exc_o,
  input logic              int_ack_o,
  input logic              hold_ack_o,
  input logic              fetch_o,
  input logic [TRAP_W-1:0] dbg_status_o
);
  p_one_action_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_o, dbg_exc_o, int_ack_o, hold_ack_o, fetch_o}))
    else $error("one action per cycle");

  p_needs_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_exc_o | int_ack_o | hold_ack_o | fetch_o) |-> $past(boundary_i))
    else $error("action without boundary");

  p_wake_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(irq_i && int_en_i))
    else $error("wake without enabled request");

  p_int_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack_o |-> $past(irq_i && int_en_i))
    else $error("acknowledge without enabled request");

  p_hold_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack_o |-> $past(hold_req_i))
    else $error("hold grant without request");

  p_fetch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> $past(!hold_req_i))
    else $error("fetch while hold requested");

  p_status_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc_o |-> (dbg_status_o != '0))
    else $error("debug exception with empty status");

  p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dbg_status_o) & ~dbg_status_o) == '0)
    else $error("status bit dropped");
endmodule

bind bep_event_prio bep_checker #(.TRAP_W(TRAP_W)) u_bep_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .boundary_i   (boundary_i),
  .irq_i        (irq_i),
  .int_en_i     (int_en_i),
  .hold_req_i   (hold_req_i),
  .wake_o       (wake_o),
  .dbg_exc_o    (dbg_exc_o),
  .int_ack_o    (int_ack_o),
  .hold_ack_o   (hold_ack_o),
  .fetch_o      (fetch_o),
  .dbg_status_o (dbg_status_o)
);

// File: tb/bep_event_prio_bench.sv
`timescale 1ns/1ps
module bep_event_prio_bench;
  localparam int TW = 32;
  localparam logic [4:0] A_NONE  = 5'b00000;
  localparam logic [4:0] A_WAKE  = 5'b10000;
  localparam logic [4:0] A_DBG   = 5'b01000;
  localparam logic [4:0] A_INT   = 5'b00100;
  localparam logic [4:0] A_HOLD  = 5'b00010;
  localparam logic [4:0] A_FETCH = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 1'b0, halt_i = 1'b0;
  logic [TW-1:0] trap_set_i = '0;
  logic [1:0] inh_set_i = '0;
  logic irq_i = 1'b0, int_en_i = 1'b0, hold_req_i = 1'b0, step_i = 1'b0;
  logic wake_o, dbg_exc_o, int_ack_o, hold_ack_o, fetch_o, ext_evt_o, pending_o;
  logic [TW-1:0] dbg_status_o;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [TW-1:0] exp_status = '0;

  always #5 clk = ~clk;

  bep_event_prio u_bep_event_prio (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .halt_i(halt_i),
    .trap_set_i(trap_set_i), .inh_set_i(inh_set_i), .irq_i(irq_i),
    .int_en_i(int_en_i), .hold_req_i(hold_req_i), .step_i(step_i),
    .wake_o(wake_o), .dbg_exc_o(dbg_exc_o), .int_ack_o(int_ack_o),
    .hold_ack_o(hold_ack_o), .fetch_o(fetch_o), .ext_evt_o(ext_evt_o),
    .dbg_status_o(dbg_status_o), .pending_o(pending_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] acts();
    return {wake_o, dbg_exc_o, int_ack_o, hold_ack_o, fetch_o};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic eval_once();
    boundary_i = 1'b1;
    tick();
    boundary_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 actions in reset", {27'd0, acts()}, {27'd0, A_NONE});
    rst_n = 1'b1;
    tick();
    check("R1 actions after reset", {27'd0, acts()}, {27'd0, A_NONE});
    check("R1 status after reset", dbg_status_o, '0);
    check("R1 nothing pending", {31'd0, pending_o}, 32'd0);
  endtask

  task automatic t_fetch();
    eval_once();
    check("R8 idle boundary fetches", {27'd0, acts()}, {27'd0, A_FETCH});
    tick();
    check("R2 pulse lasts one cycle", {27'd0, acts()}, {27'd0, A_NONE});
  endtask

  task automatic t_interrupt();
    irq_i = 1'b1; int_en_i = 1'b0;
    eval_once();
    check("R6 disabled request ignored", {27'd0, acts()}, {27'd0, A_FETCH});
    int_en_i = 1'b1;
    eval_once();
    check("R6 interrupt taken", {27'd0, acts()}, {27'd0, A_INT});
    check("R6 external mark", {31'd0, ext_evt_o}, 32'd1);
    hold_req_i = 1'b1;
    eval_once();
    check("R7 interrupt beats hold", {27'd0, acts()}, {27'd0, A_INT});
    irq_i = 1'b0; int_en_i = 1'b0;
    eval_once();
    check("R7 hold granted", {27'd0, acts()}, {27'd0, A_HOLD});
    hold_req_i = 1'b0;
  endtask

  task automatic t_inhibit();
    inh_set_i = 2'b01;
    tick();
    inh_set_i = 2'b00;
    irq_i = 1'b1; int_en_i = 1'b1;
    eval_once();
    check("R11 inhibited boundary skips interrupt", {27'd0, acts()}, {27'd0, A_FETCH});
    inh_set_i = 2'b01;
    eval_once();
    inh_set_i = 2'b00;
    check("R11 mask cleared, interrupt taken", {27'd0, acts()}, {27'd0, A_INT});
    eval_once();
    check("R11 same-cycle inhibit applies next", {27'd0, acts()}, {27'd0, A_FETCH});
    eval_once();
    check("R11 inhibit lasted one boundary", {27'd0, acts()}, {27'd0, A_INT});
    irq_i = 1'b0; int_en_i = 1'b0;
  endtask

  task automatic t_traps();
    trap_set_i = 32'h8; inh_set_i = 2'b10;
    tick();
    trap_set_i = '0; inh_set_i = 2'b00;
    check("R10 trap keeps pending", {31'd0, pending_o}, 32'd1);
    eval_once();
    check("R5 inhibited trap waits", {27'd0, acts()}, {27'd0, A_FETCH});
    eval_once();
    exp_status = exp_status | 32'h8;
    check("R5 trap raised next boundary", {27'd0, acts()}, {27'd0, A_DBG});
    check("R5 status holds trap bit", dbg_status_o, exp_status);
    eval_once();
    check("R5 trap consumed", {27'd0, acts()}, {27'd0, A_FETCH});
  endtask

  task automatic t_task();
    trap_set_i = 32'h0000_8004; inh_set_i = 2'b10;
    tick();
    trap_set_i = '0; inh_set_i = 2'b00;
    irq_i = 1'b1; int_en_i = 1'b1;
    eval_once();
    exp_status = exp_status | 32'h0000_8004;
    check("R4 task trap beats inhibit and interrupt", {27'd0, acts()}, {27'd0, A_DBG});
    check("R4 status accumulates", dbg_status_o, exp_status);
    irq_i = 1'b0; int_en_i = 1'b0;
  endtask

  task automatic t_same_cycle_trap();
    trap_set_i = 32'h20;
    eval_once();
    trap_set_i = '0;
    check("R12 bit not seen same cycle", {27'd0, acts()}, {27'd0, A_FETCH});
    eval_once();
    exp_status = exp_status | 32'h20;
    check("R12 bit seen next boundary", {27'd0, acts()}, {27'd0, A_DBG});
    check("R12 status", dbg_status_o, exp_status);
  endtask

  task automatic t_step();
    step_i = 1'b1;
    #1;
    check("R10 step flag pending", {31'd0, pending_o}, 32'd1);
    eval_once();
    step_i = 1'b0;
    check("R9 stepped instruction fetches", {27'd0, acts()}, {27'd0, A_FETCH});
    eval_once();
    exp_status = exp_status | 32'h4000;
    check("R9 step trap reported", {27'd0, acts()}, {27'd0, A_DBG});
    check("R9 step status bit", dbg_status_o, exp_status);
  endtask

  task automatic t_halt();
    halt_i = 1'b1;
    tick();
    halt_i = 1'b0;
    hold_req_i = 1'b1;
    eval_once();
    hold_req_i = 1'b0;
    check("R3 halted boundary ignored", {27'd0, acts()}, {27'd0, A_NONE});
    trap_set_i = 32'h80; inh_set_i = 2'b11;
    tick();
    trap_set_i = '0; inh_set_i = 2'b00;
    irq_i = 1'b1; int_en_i = 1'b0;
    tick();
    tick();
    check("R3 disabled request no wake", {27'd0, acts()}, {27'd0, A_NONE});
    int_en_i = 1'b1;
    tick();
    check("R3 wake pulse", {27'd0, acts()}, {27'd0, A_WAKE});
    eval_once();
    check("R3 wake cleared trap and inhibit", {27'd0, acts()}, {27'd0, A_INT});
    irq_i = 1'b0; int_en_i = 1'b0;
    eval_once();
    check("R3 no trap left", {27'd0, acts()}, {27'd0, A_FETCH});
    check("R3 status unchanged", dbg_status_o, exp_status);
    check("R10 all quiet", {31'd0, pending_o}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_fetch();
    t_interrupt();
    t_inhibit();
    t_traps();
    t_task();
    t_same_cycle_trap();
    t_step();
    t_halt();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule